// File: doc/BRIEF.md
# Serial shift-add unsigned multiplier

This block multiplies two unsigned W-bit numbers by taking one of them in parallel and the other one bit at a time. A start pulse latches the parallel operand (the multiplicand) and zeroes an internal running sum. Each accepted multiplier bit does three things in the same cycle:

- It gates the stored multiplicand.
- The gated value is added to the running sum by a single W-bit combinational adder.
- The lowest bit of that sum leaves the block as the next low product bit, and the rest of the sum becomes the new running sum.

After W accepted bits the running sum holds the upper half of the 2W-bit product, and a one-cycle done pulse marks this.

The serial input and the serial output are coupled stream ports, and one step is one transfer on each port at the same time. The rules are as follows:

- `mbit_ready` is high only while a multiplication is in progress and the consumer asserts `pbit_ready`.
- `pbit_valid` is high only while a multiplication is in progress and the producer asserts `mbit_valid`.
- A step happens on a rising edge where `mbit_valid`, `mbit_ready`, `pbit_valid` and `pbit_ready` are all high.
- Either side may stall for any number of cycles by dropping its signal. Nothing changes during a stall.
- The `pbit` value is valid only while `pbit_valid` is high.

Top module: `serial_shift_mult`

## Requirements
- R1: A cycle with `start` high latches `mcand`, clears the running sum so that `prod_hi` reads 0 on the next cycle, and begins a multiplication of W steps.
- R2: `mbit_ready` equals busy AND `pbit_ready`, and `pbit_valid` equals busy AND `mbit_valid`. A step takes place only on an edge where both transfers happen together.
- R3: On each step, `pbit` is bit 0 of (running sum + (`mbit` ? multiplicand : 0)). The new running sum is that (W+1)-bit total shifted right by one.
- R4: Across the W steps of one multiplication, the `pbit` values are product bits 0 through W-1, lowest first.
- R5: One cycle after the W-th step, `done` is high for exactly one cycle and `prod_hi` equals product bits 2W-1 down to W. After that, `prod_hi` holds its value until the next start.
- R6: A cycle with no step leaves `prod_hi` and the step count unchanged. A multiplication with stalls on either side gives the same product as one with no stalls.
- R7: After reset, busy, `done`, `mbit_ready` and `pbit_valid` are low and `prod_hi` is 0.
- R8: A start while a multiplication is in progress abandons it and begins a new one from a zero running sum, with the new multiplicand.
- R9: Changes on `mcand` after the start cycle have no effect on the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; latches `mcand` |
| mcand | input | W | Parallel multiplicand |
| mbit | input | 1 | Serial multiplier bit, least significant first |
| mbit_valid | input | 1 | `mbit` is offered |
| mbit_ready | output | 1 | Block can take `mbit` this cycle |
| pbit | output | 1 | Serial low product bit |
| pbit_valid | output | 1 | `pbit` is offered |
| pbit_ready | input | 1 | Consumer can take `pbit` this cycle |
| prod_hi | output | W | Upper half of the product, valid when `done` |
| done | output | 1 | One-cycle pulse after the final step |

## Verification
The bench runs every pair of 5-bit operands, with stall patterns that vary between runs on both the input side and the output side. The following faults would show up in these runs:

- A carry that is dropped out of the adder's top bit corrupts the upper half. This appears for large operand pairs such as 31 × 31.
- A shift taken from the wrong bit scrambles the serial low bits.
- Advancing on only one of the two handshakes adds extra steps during stalls, so the product comes out wrong and `prod_hi` moves while it should not.

Further cases the bench exercises:

- A restart in the middle of a multiplication must not leave residue from the abandoned one.
- Changing `mcand` after start must not alter the product.
- An off-by-one step count shows up as a `done` pulse in the wrong cycle or a `done` pulse longer than one cycle.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ssm_state_e;

  function automatic int ssm_cnt_bits(input int w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/ssm_gate_add.sv
module ssm_gate_add #(
  parameter int W = 5
) (
  input  logic [W-1:0] mcand_q,
  input  logic         mbit,
  input  logic [W-1:0] psum,
  output logic [W:0]   total
);
  logic [W-1:0] gated;

  for (genvar j = 0; j < W; j++) begin : g_gate
    assign gated[j] = mcand_q[j] & mbit;
  end

  assign total = {1'b0, psum} + {1'b0, gated};
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic busy,
  output logic done
);
  localparam int CW = ssm_cnt_bits(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  ssm_state_e       state;
  logic [CW-1:0]    cnt;

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= ST_RUN;
        cnt   <= '0;
      end else if (step) begin
        if (cnt == LAST) begin
          state <= ST_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: done lasts a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: the count never passes the last step
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R6: no step and no start keeps the count
  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step) |=> $stable(cnt));
  // R5: done follows only the final step
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(step) && !busy));
endmodule

// File: rtl/ssm_acc.sv
module ssm_acc #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic [W-1:0] mcand,
  input  logic [W:0]   total,
  output logic [W-1:0] mcand_q,
  output logic [W-1:0] psum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      psum    <= '0;
    end else if (start) begin
      mcand_q <= mcand;
      psum    <= '0;
    end else if (step) begin
      psum <= total[W:1];
    end
  end

  // R1: start leaves a zero running sum
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (psum == '0));
  // R9: latched multiplicand only moves on start
  a_r9_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mcand_q));
  // R6: running sum frozen without a step
  a_r6_psum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step) |=> $stable(psum));
endmodule

// File: rtl/serial_shift_mult.sv
module serial_shift_mult #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic         mbit,
  input  logic         mbit_valid,
  output logic         mbit_ready,
  output logic         pbit,
  output logic         pbit_valid,
  input  logic         pbit_ready,
  output logic [W-1:0] prod_hi,
  output logic         done
);
  logic         busy;
  logic         step;
  logic [W-1:0] mcand_q;
  logic [W-1:0] psum;
  logic [W:0]   total;

  assign mbit_ready = busy & pbit_ready;
  assign pbit_valid = busy & mbit_valid;
  assign step       = mbit_ready & mbit_valid & !start;
  assign pbit       = total[0];
  assign prod_hi    = psum;

  ssm_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  ssm_gate_add #(.W(W)) u_add (
    .mcand_q (mcand_q),
    .mbit    (mbit),
    .psum    (psum),
    .total   (total)
  );

  ssm_acc #(.W(W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .step    (step),
    .mcand   (mcand),
    .total   (total),
    .mcand_q (mcand_q),
    .psum    (psum)
  );

  // R2: the two handshakes complete together
  a_r2_paired: assert property (@(posedge clk) disable iff (!rst_n)
    (mbit_valid && mbit_ready) |-> (pbit_valid && pbit_ready));
  // R2: nothing offered while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mbit_ready && !pbit_valid));
  // R3: a zero multiplier bit passes the running sum's low bit straight out
  a_r3_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (pbit_valid && !mbit) |-> (pbit == prod_hi[0]));
  // R6: upper half held across idle cycles after done
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(prod_hi));
endmodule

// File: tb/serial_shift_mult_bench.sv
module serial_shift_mult_bench;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic         mbit = 1'b0;
  logic         mbit_valid = 1'b0;
  logic         mbit_ready;
  logic         pbit;
  logic         pbit_valid;
  logic         pbit_ready = 1'b0;
  logic [W-1:0] prod_hi;
  logic         done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_shift_mult #(.W(W)) u_serial_shift_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mbit(mbit), .mbit_valid(mbit_valid), .mbit_ready(mbit_ready),
    .pbit(pbit), .pbit_valid(pbit_valid), .pbit_ready(pbit_ready),
    .prod_hi(prod_hi), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One multiplication with a deterministic stall pattern chosen by seed.
  task automatic run_mult(input int a, input int b, input int seed, input int abort_after);
    logic [2*W-1:0] prod;
    logic [W-1:0]   lo;
    logic [W-1:0]   ph;
    int             i;
    int             cyc;
    bit             stalled;
    prod = (2*W)'(a * b);
    lo = '0;
    @(negedge clk);
    start = 1'b1; mcand = W'(a); mbit_valid = 1'b0; pbit_ready = 1'b0;
    @(negedge clk);
    start = 1'b0; mcand = ~W'(a);           // R9: later mcand must be ignored
    check("R1 prod_hi cleared", 32'(prod_hi), 0);
    i = 0; cyc = 0;
    while (i < W) begin
      stalled = ((seed + cyc) % 4 == 3) || ((seed * 7 + cyc) % 5 == 4);
      mbit = b[i];
      mbit_valid = !((seed + cyc) % 4 == 3);
      pbit_ready = !((seed * 7 + cyc) % 5 == 4);
      #1;
      if (!stalled) begin
        check("R2 pbit_valid", 32'(pbit_valid), 1);
        check("R2 mbit_ready", 32'(mbit_ready), 1);
        lo[i] = pbit;
        i++;
        if (abort_after > 0 && i == abort_after) begin
          @(negedge clk);
          mbit_valid = 1'b0; pbit_ready = 1'b0;
          return;
        end
      end
      ph = prod_hi;
      @(negedge clk);
      if (stalled) check("R6 stall holds prod_hi", 32'(prod_hi), 32'(ph));
      cyc++;
    end
    mbit_valid = 1'b0; pbit_ready = 1'b0;
    check("R5 done after last step", 32'(done), 1);
    check("R5 prod_hi upper half", 32'(prod_hi), 32'(prod[2*W-1:W]));
    check("R4 R3 serial low bits", 32'(lo), 32'(prod[W-1:0]));
    @(negedge clk);
    check("R5 done one cycle", 32'(done), 0);
    check("R5 prod_hi held", 32'(prod_hi), 32'(prod[2*W-1:W]));
    check("R2 idle no ready", 32'(mbit_ready), 0);
  endtask

  initial begin
    #1;
    check("R7 done low in reset", 32'(done), 0);
    check("R7 prod_hi zero", 32'(prod_hi), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pbit_ready = 1'b1; mbit_valid = 1'b1;
    #1;
    check("R7 mbit_ready idle", 32'(mbit_ready), 0);
    check("R7 pbit_valid idle", 32'(pbit_valid), 0);
    check("R7 done after reset", 32'(done), 0);
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_mult(a, b, a * 3 + b, 0);
      end
    end
    // R8: restart mid-run, then a full run must be clean
    run_mult(31, 31, 1, 2);
    run_mult(19, 27, 2, 0);
    run_mult(31, 31, 0, 4);
    run_mult(31, 31, 5, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule